// File: doc/BRIEF.md
# Hybrid Wired/Wireless Mesh Route Computation Unit

This unit picks the output port for the head flit of a packet in a 6×6 mesh. The mesh is split into four 3×3 regions, and the centre router of each region carries a radio. A flit may be injected locally or arrive from a neighbour. The unit takes the current router's coordinates, the destination coordinates and the direction the flit was travelling on arrival. Inside one region it routes X first, then Y. A packet bound for another region is first steered over wires to its own region's hub. The hub then sends it in one radio hop to the destination region's hub. From there it continues over wires.

Every hub pair has its own radio channel, and the unit reports which of the six channels to use. Each requested turn from the arrival direction to the chosen output is checked against eight forbidden turns, all of which involve a diagonal port. A forbidden turn produces an error result in place of a valid one. Only head flits are presented, because body flits follow the path of their head. The result is held in one output register with a valid/ready handshake.

Top module: `hybrid_route_unit`

## Requirements
- R1: After reset, valid_o and err_o are low and ready_o is high.
- R2: When the destination equals the current node, the result is port LOCAL (code 0).
- R3: When the current node and the destination share a region (region index = 2*(y/3) + x/3), the result follows X-then-Y order. Moving east (code 2) means x increases, west (code 4) means x decreases, north (code 1) means y increases and south (code 3) means y decreases. X is resolved before Y.
- R4: When the regions differ and the current node is not its region's hub, the result is the X-then-Y step toward that hub. The hub of a region is at (3*(x/3)+1, 3*(y/3)+1).
- R5: When the regions differ and the current node is its region's hub, the result is port WIRELESS (code 9). For regions a<b, chan_o equals a*(7-a)/2 + (b-a-1). This gives six channels, numbered 0 to 5.
- R6: chan_o is 0 on every result whose port is not WIRELESS.
- R7: The arrival→output pairs W→SE, N→SW, E→NW, S→NE, NE→S, NW→E, SW→N and SE→W produce an error result. Such a result has err_o high and valid_o low. The diagonal codes are NE=5, NW=6, SE=7 and SW=8. Every other pair produces valid_o high.
- R8: Following the route hop by hop from injection (arrival LOCAL), with each later arrival direction equal to the previous output, never produces an error result.
- R9: A held result stays stable while ready_i is low. ready_o is high exactly when the stage is empty or is draining. A new head flit is accepted in the same cycle that the old result drains.
- R10: The result appears on the cycle after the clock edge that accepts valid_i with ready_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Head flit request present |
| ready_o | output | 1 | Request can be taken this cycle |
| cur_x_i | input | 3 | Current router x |
| cur_y_i | input | 3 | Current router y |
| dst_x_i | input | 3 | Destination x |
| dst_y_i | input | 3 | Destination y |
| in_dir_i | input | 4 | Travel direction on arrival (port code) |
| valid_o | output | 1 | Legal route result held |
| err_o | output | 1 | Forbidden-turn result held |
| ready_i | input | 1 | Consumer takes the held result |
| port_o | output | 4 | Selected output port code |
| chan_o | output | 3 | Hub-pair radio channel |

## Verification
The output register can release a held result and capture a new head flit on the same edge. Back-to-back hop-by-hop walks over all 1296 source/destination pairs exercise this case. In one phase ready_i is driven by a pseudo-random pattern, so that some drains coincide with new requests and others stall them. A scoreboard queue fixes the expected order of results. A result that is lost, duplicated or overwritten during a stall therefore shows up as a port, channel or error mismatch at the consumer.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
  localparam int MESH_DIM = 6;
  localparam int REG_DIM  = 3;
  localparam int REG_SIDE = MESH_DIM / REG_DIM;
  localparam int NUM_REG  = REG_SIDE * REG_SIDE;
  localparam int NUM_CHAN = NUM_REG * (NUM_REG - 1) / 2;
  localparam int CW       = $clog2(MESH_DIM);
  localparam int RW       = $clog2(NUM_REG);
  localparam int CHW      = $clog2(NUM_CHAN);
  localparam int PW       = 4;

  typedef enum logic [PW-1:0] {
    PORT_LOCAL = 4'd0,
    PORT_N     = 4'd1,
    PORT_E     = 4'd2,
    PORT_S     = 4'd3,
    PORT_W     = 4'd4,
    PORT_NE    = 4'd5,
    PORT_NW    = 4'd6,
    PORT_SE    = 4'd7,
    PORT_SW    = 4'd8,
    PORT_WL    = 4'd9
  } port_e;
endpackage

// File: rtl/hrc_region_map.sv
module hrc_region_map
  import hrc_pkg::*;
(
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  output logic [RW-1:0] reg_o
);
  int rx, ry;
  always_comb begin
    rx    = int'(x_i) / REG_DIM;
    ry    = int'(y_i) / REG_DIM;
    reg_o = RW'(ry * REG_SIDE + rx);
  end
endmodule

// File: rtl/hrc_hub_locate.sv
module hrc_hub_locate
  import hrc_pkg::*;
(
  input  logic [RW-1:0] reg_i,
  output logic [CW-1:0] hub_x_o,
  output logic [CW-1:0] hub_y_o
);
  int rx, ry;
  always_comb begin
    rx      = int'(reg_i) % REG_SIDE;
    ry      = int'(reg_i) / REG_SIDE;
    hub_x_o = CW'(rx * REG_DIM + REG_DIM / 2);
    hub_y_o = CW'(ry * REG_DIM + REG_DIM / 2);
  end
endmodule

// File: rtl/hrc_chan_map.sv
module hrc_chan_map
  import hrc_pkg::*;
(
  input  logic [RW-1:0]  reg_a_i,
  input  logic [RW-1:0]  reg_b_i,
  output logic [CHW-1:0] chan_o
);
  int lo, hi, idx;
  // triangular index of the unordered hub pair
  always_comb begin
    lo  = (reg_a_i < reg_b_i) ? int'(reg_a_i) : int'(reg_b_i);
    hi  = (reg_a_i < reg_b_i) ? int'(reg_b_i) : int'(reg_a_i);
    idx = lo * (2 * NUM_REG - lo - 1) / 2 + hi - lo - 1;
    chan_o = (lo == hi) ? '0 : CHW'(idx);
  end
endmodule

// File: rtl/hrc_port_sel.sv
module hrc_port_sel
  import hrc_pkg::*;
(
  input  logic [CW-1:0] cur_x_i,
  input  logic [CW-1:0] cur_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  input  logic [RW-1:0] cur_reg_i,
  input  logic [RW-1:0] dst_reg_i,
  input  logic [CW-1:0] hub_x_i,
  input  logic [CW-1:0] hub_y_i,
  output port_e         port_o
);
  logic          same_reg, at_dst, at_hub;
  logic [CW-1:0] tgt_x, tgt_y;

  always_comb begin
    same_reg = (cur_reg_i == dst_reg_i);
    at_dst   = (cur_x_i == dst_x_i) && (cur_y_i == dst_y_i);
    at_hub   = (cur_x_i == hub_x_i) && (cur_y_i == hub_y_i);
    // inter-region traffic heads for the local hub first
    tgt_x    = same_reg ? dst_x_i : hub_x_i;
    tgt_y    = same_reg ? dst_y_i : hub_y_i;
    if (at_dst)                   port_o = PORT_LOCAL;
    else if (!same_reg && at_hub) port_o = PORT_WL;
    else if (tgt_x > cur_x_i)     port_o = PORT_E;
    else if (tgt_x < cur_x_i)     port_o = PORT_W;
    else if (tgt_y > cur_y_i)     port_o = PORT_N;
    else                          port_o = PORT_S;
  end
endmodule

// File: rtl/hrc_turn_check.sv
module hrc_turn_check
  import hrc_pkg::*;
(
  input  logic [PW-1:0] in_dir_i,
  input  port_e         out_i,
  output logic          bad_o
);
  always_comb begin
    unique case ({in_dir_i, out_i})
      {PORT_W,  PORT_SE}, {PORT_N,  PORT_SW},
      {PORT_E,  PORT_NW}, {PORT_S,  PORT_NE}: bad_o = 1'b1;
      {PORT_NE, PORT_S},  {PORT_NW, PORT_E},
      {PORT_SW, PORT_N},  {PORT_SE, PORT_W}:  bad_o = 1'b1;
      default:                                bad_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hrc_out_stage.sv
module hrc_out_stage
  import hrc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  output logic           ready_o,
  input  logic           bad_i,
  input  logic [PW-1:0]  port_i,
  input  logic [CHW-1:0] chan_i,
  output logic           valid_o,
  output logic           err_o,
  input  logic           ready_i,
  output logic [PW-1:0]  port_o,
  output logic [CHW-1:0] chan_o
);
  logic full;
  assign full    = valid_o | err_o;
  assign ready_o = !full || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      port_o  <= '0;
      chan_o  <= '0;
    end else if (ready_o) begin
      valid_o <= valid_i && !bad_i;
      err_o   <= valid_i && bad_i;
      if (valid_i) begin
        port_o <= port_i;
        chan_o <= chan_i;
      end
    end
  end
endmodule

// File: rtl/hybrid_route_unit.sv
module hybrid_route_unit
  import hrc_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  output logic           ready_o,
  input  logic [CW-1:0]  cur_x_i,
  input  logic [CW-1:0]  cur_y_i,
  input  logic [CW-1:0]  dst_x_i,
  input  logic [CW-1:0]  dst_y_i,
  input  logic [PW-1:0]  in_dir_i,
  output logic           valid_o,
  output logic           err_o,
  input  logic           ready_i,
  output logic [PW-1:0]  port_o,
  output logic [CHW-1:0] chan_o
);
  localparam int NPT = 2; // current node, destination

  logic [CW-1:0]  pt_x   [NPT];
  logic [CW-1:0]  pt_y   [NPT];
  logic [RW-1:0]  pt_reg [NPT];
  logic [CW-1:0]  hub_x, hub_y;
  logic [CHW-1:0] pair_chan, sel_chan;
  port_e          sel_port;
  logic           turn_bad;

  assign pt_x[0] = cur_x_i;
  assign pt_y[0] = cur_y_i;
  assign pt_x[1] = dst_x_i;
  assign pt_y[1] = dst_y_i;

  for (genvar g = 0; g < NPT; g++) begin : g_reg
    hrc_region_map u_map (
      .x_i   (pt_x[g]),
      .y_i   (pt_y[g]),
      .reg_o (pt_reg[g])
    );
  end

  hrc_hub_locate u_hub (
    .reg_i   (pt_reg[0]),
    .hub_x_o (hub_x),
    .hub_y_o (hub_y)
  );

  hrc_chan_map u_chan (
    .reg_a_i (pt_reg[0]),
    .reg_b_i (pt_reg[1]),
    .chan_o  (pair_chan)
  );

  hrc_port_sel u_sel (
    .cur_x_i   (cur_x_i),
    .cur_y_i   (cur_y_i),
    .dst_x_i   (dst_x_i),
    .dst_y_i   (dst_y_i),
    .cur_reg_i (pt_reg[0]),
    .dst_reg_i (pt_reg[1]),
    .hub_x_i   (hub_x),
    .hub_y_i   (hub_y),
    .port_o    (sel_port)
  );

  hrc_turn_check u_turn (
    .in_dir_i (in_dir_i),
    .out_i    (sel_port),
    .bad_o    (turn_bad)
  );

  assign sel_chan = (sel_port == PORT_WL) ? pair_chan : '0;

  hrc_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ready_o (ready_o),
    .bad_i   (turn_bad),
    .port_i  (sel_port),
    .chan_i  (sel_chan),
    .valid_o (valid_o),
    .err_o   (err_o),
    .ready_i (ready_i),
    .port_o  (port_o),
    .chan_o  (chan_o)
  );
endmodule

// File: rtl/hybrid_route_unit_chk.sv
module hybrid_route_unit_chk
  import hrc_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic           ready_o,
  input logic [CW-1:0]  cur_x_i,
  input logic [CW-1:0]  cur_y_i,
  input logic [CW-1:0]  dst_x_i,
  input logic [CW-1:0]  dst_y_i,
  input logic [PW-1:0]  in_dir_i,
  input logic           valid_o,
  input logic           err_o,
  input logic           ready_i,
  input logic [PW-1:0]  port_o,
  input logic [CHW-1:0] chan_o
);
  // R2
  self_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o && cur_x_i == dst_x_i && cur_y_i == dst_y_i
    |=> valid_o && port_o == PORT_LOCAL);

  // R5
  chan_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && port_o == PORT_WL |-> chan_o < CHW'(NUM_CHAN));

  // R6
  chan_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && port_o != PORT_WL |-> chan_o == '0);

  // R7
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  // R8
  card_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o && in_dir_i inside {PORT_LOCAL, PORT_N, PORT_E, PORT_S, PORT_W, PORT_WL}
    |=> valid_o && !err_o);

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || err_o) && !ready_i
    |=> $stable(port_o) && $stable(chan_o) && $stable(valid_o) && $stable(err_o));

  // R9
  stall_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || err_o) && !ready_i |-> !ready_o);

  // R10
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> valid_o || err_o);
endmodule

bind hybrid_route_unit hybrid_route_unit_chk chk_i (.*);

// File: tb/hybrid_route_unit_tb_top.sv
module hybrid_route_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic       ready_o;
  logic [2:0] cur_x_i = '0, cur_y_i = '0, dst_x_i = '0, dst_y_i = '0;
  logic [3:0] in_dir_i = '0;
  logic       valid_o, err_o;
  logic       ready_i = 1'b1;
  logic [3:0] port_o;
  logic [2:0] chan_o;

  always #2 clk_i = ~clk_i; // 250 MHz

  hybrid_route_unit dut_i (.*);

  typedef struct {
    logic [3:0] port;
    logic [2:0] chan;
    logic       err;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  int   cyc   = 0;
  logic stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic done = 1'b0;

  localparam logic [3:0] P_L = 0, P_N = 1, P_E = 2, P_S = 3, P_W = 4,
                         P_NE = 5, P_NW = 6, P_SE = 7, P_SW = 8, P_WL = 9;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int reg_of(int x, int y);
    return 2 * (y / 3) + x / 3;
  endfunction

  function automatic logic [3:0] m_port(int cx, int cy, int dx, int dy);
    int tx, ty;
    if (cx == dx && cy == dy) return P_L;
    if (reg_of(cx, cy) != reg_of(dx, dy)) begin
      tx = 3 * (cx / 3) + 1;
      ty = 3 * (cy / 3) + 1;
      if (cx == tx && cy == ty) return P_WL;
    end else begin
      tx = dx;
      ty = dy;
    end
    if (tx != cx) return (tx > cx) ? P_E : P_W;
    return (ty > cy) ? P_N : P_S;
  endfunction

  function automatic logic [2:0] m_chan(int a, int b);
    int lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    if (lo == 0) return 3'(hi - 1);
    if (lo == 1) return 3'(hi + 1);
    return 3'd5;
  endfunction

  function automatic logic m_bad(logic [3:0] i, logic [3:0] o);
    return (i == P_W  && o == P_SE) || (i == P_N  && o == P_SW) ||
           (i == P_E  && o == P_NW) || (i == P_S  && o == P_NE) ||
           (i == P_NE && o == P_S)  || (i == P_NW && o == P_E)  ||
           (i == P_SW && o == P_N)  || (i == P_SE && o == P_W);
  endfunction

  task automatic send(input int cx, input int cy, input int dx, input int dy,
                      input logic [3:0] indir, input string tag);
    exp_t e;
    e.port = m_port(cx, cy, dx, dy);
    e.chan = (e.port == P_WL) ? m_chan(reg_of(cx, cy), reg_of(dx, dy)) : 3'd0;
    e.err  = m_bad(indir, e.port);
    e.tag  = tag;
    @(negedge clk_i);
    valid_i  = 1'b1;
    cur_x_i  = 3'(cx); cur_y_i = 3'(cy);
    dst_x_i  = 3'(dx); dst_y_i = 3'(dy);
    in_dir_i = indir;
    #1;
    while (!ready_o) begin
      @(negedge clk_i);
      #1;
    end
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  function automatic string cls(int cx, int cy, int dx, int dy);
    if (cx == dx && cy == dy) return "R2";
    if (reg_of(cx, cy) == reg_of(dx, dy)) return "R3";
    if (cx == 3 * (cx / 3) + 1 && cy == 3 * (cy / 3) + 1) return "R5";
    return "R4";
  endfunction

  // hop-by-hop walk; every result must be legal (R8)
  task automatic walk(input int sx, input int sy, input int dx, input int dy);
    int x, y;
    logic [3:0] dir, p;
    x = sx; y = sy; dir = P_L;
    for (int h = 0; h < 16; h++) begin
      p = m_port(x, y, dx, dy);
      send(x, y, dx, dy, dir, {cls(x, y, dx, dy), "/R8"});
      if (p == P_L) break;
      case (p)
        P_N:     y = y + 1;
        P_S:     y = y - 1;
        P_E:     x = x + 1;
        P_W:     x = x - 1;
        default: begin x = 3 * (dx / 3) + 1; y = 3 * (dy / 3) + 1; end
      endcase
      dir = p;
    end
  endtask

  always @(negedge clk_i) begin
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ready_i <= stall_mode ? lfsr[0] : 1'b1;
  end

  // monitor: compares on each consumed result; port/chan compare covers R6
  always begin
    exp_t e;
    @(negedge clk_i);
    #1;
    if (rst_ni && (valid_o || err_o) && ready_i) begin
      check(ready_o, "R9 ready_o during drain", int'(ready_o), 1);
      if (sb_q.size() == 0) begin
        check(1'b0, "R10 unexpected result", int'(port_o), -1);
      end else begin
        e = sb_q.pop_front();
        check(err_o == e.err, {e.tag, "/R7 err_o"}, int'(err_o), int'(e.err));
        check(valid_o == !e.err, {e.tag, "/R7 valid_o"}, int'(valid_o), int'(!e.err));
        check(port_o == e.port, {e.tag, " port_o"}, int'(port_o), int'(e.port));
        check(chan_o == e.chan, {e.tag, "/R6 chan_o"}, int'(chan_o), int'(e.chan));
      end
    end
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check(!valid_o, "R1 valid_o", int'(valid_o), 0);
    check(!err_o, "R1 err_o", int'(err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    check(ready_o, "R1 ready_o", int'(ready_o), 1);

    // R10: one-cycle latency
    send(0, 0, 2, 0, P_L, "R10/R3");
    idle();
    #1;
    check(valid_o, "R10 valid_o next cycle", int'(valid_o), 1);
    idle();

    // R7: forbidden turns from diagonal arrivals
    send(2, 2, 2, 0, P_NE, "R7 NE->S");
    send(0, 0, 0, 2, P_SW, "R7 SW->N");
    send(0, 0, 2, 0, P_NW, "R7 NW->E");
    send(2, 0, 0, 0, P_SE, "R7 SE->W");
    send(0, 0, 2, 0, P_NE, "R7 NE->E legal");
    send(1, 1, 4, 4, P_SE, "R7 SE->WL legal");
    // R5: every hub pair channel
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        if (a != b) send(3 * (a % 2) + 1, 3 * (a / 2) + 1, 3 * (b % 2) + 1, 3 * (b / 2), P_W, "R5");

    // all pairs, back-to-back (R2/R3/R4/R5/R8/R9)
    for (int s = 0; s < 36; s++)
      for (int d = 0; d < 36; d++)
        walk(s % 6, s / 6, d % 6, d / 6);

    // R9: random consumer stalls
    stall_mode = 1'b1;
    for (int s = 0; s < 36; s += 5)
      for (int d = 0; d < 36; d += 3)
        walk(s % 6, s / 6, d % 6, d / 6);
    idle();
    stall_mode = 1'b0;

    for (int w = 0; w < 200 && sb_q.size() != 0; w++) @(negedge clk_i);
    check(sb_q.size() == 0, "R9 drain", sb_q.size(), 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule